// File: doc/BRIEF.md
# Universal Shift Register with Shared Bus Lines

This block is a parameterized register, eight bits wide by default, that holds, shifts toward its high end, shifts toward its low end or loads a whole word, as chosen by two mode inputs. Its parallel lines are meant to connect to a shared bus. Each line is modelled as three separate signals: an input value, an output value and a drive enable. A pad ring or a top-level tri-state wrapper combines them into a real bidirectional pin. In load mode the drivers release the lines on their own, so that the same wires can bring in the word that will be captured.

The lowest and highest register bits also appear on two serial outputs that are never disabled. Several instances can therefore be chained into a longer word. Each instance's high end bit feeds the next instance's low-end serial input, and each instance's low end bit feeds back into the previous instance's high-end serial input. An active-low reset clears the register at once, without waiting for a clock edge. Two active-high disable inputs force the parallel drivers off, and the register keeps working while they are off.

Top module: `usr_bus_shreg`

## Requirements
- R1: With mode code {mode_hi,mode_lo} = 00 (hold), a rising clock edge leaves every register bit unchanged.
- R2: With mode code 01 (shift up), a rising clock edge moves each bit n to bit n+1 and puts ser_up_in into bit 0. The old top bit is dropped.
- R3: With mode code 10 (shift down), a rising clock edge moves each bit n to bit n-1 and puts ser_dn_in into the top bit. The old bit 0 is dropped.
- R4: With mode code 11 (load), a rising clock edge copies bus_in into the register.
- R5: When rst_n goes low, all register bits clear at once, without a clock edge. While rst_n stays low, the register stays zero whatever the mode inputs or the clock do.
- R6: If dis_a or dis_b is high, every bit of bus_oe is 0. Hold, shift, load and reset still work as in R1 to R5.
- R7: In load mode (code 11), every bit of bus_oe is 0, whatever the disable inputs are.
- R8: When both disable inputs are low and the mode is not load, every bit of bus_oe is 1. bus_out always carries the register contents.
- R9: end_lo always equals register bit 0 and end_hi always equals the top register bit, whatever the enables are.
- R10: Two instances chained through their end bits and serial inputs behave as a single register of twice the width, for both shift directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_lo | input | 1 | Mode select, low bit |
| mode_hi | input | 1 | Mode select, high bit |
| ser_up_in | input | 1 | Serial input that enters bit 0 on a shift up |
| ser_dn_in | input | 1 | Serial input that enters the top bit on a shift down |
| dis_a | input | 1 | Parallel driver disable, active high |
| dis_b | input | 1 | Parallel driver disable, active high |
| bus_in | input | W | Value present on the parallel lines |
| bus_out | output | W | Register contents, driven onto the lines |
| bus_oe | output | W | Drive enable for each parallel line |
| end_lo | output | 1 | Register bit 0, always active |
| end_hi | output | 1 | Top register bit, always active |

## Verification
The clocked properties assume that the mode, serial and bus inputs are stable around each rising edge. They also assume that rst_n is released away from a clock edge. The bench meets both assumptions by changing every input on the falling edge, including the release of reset. The one exception is the reset assertion, which the bench deliberately places in mid-cycle to show that the clear does not wait for a clock. The bus_in lines are taken to carry a defined value whenever load is selected, and the bench always drives them, never leaving them floating.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_next_state.sv
module usr_next_state
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  mode_e          mode,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   load_val,
  input  logic           ser_up,
  input  logic           ser_dn,
  output logic [W-1:0]   nxt
);
  always_comb begin
    unique case (mode)
      MODE_HOLD: nxt = cur;
      MODE_UP:   nxt = {cur[W-2:0], ser_up};
      MODE_DN:   nxt = {ser_dn, cur[W-1:1]};
      MODE_LOAD: nxt = load_val;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/usr_drive_ctl.sv
module usr_drive_ctl
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  mode_e        mode,
  input  logic         dis_a,
  input  logic         dis_b,
  output logic [W-1:0] oe
);
  logic drive;
  assign drive = !(dis_a || dis_b) && (mode != MODE_LOAD);

  for (genvar i = 0; i < W; i++) begin : g_line
    assign oe[i] = drive;
  end
endmodule

// File: rtl/usr_bus_shreg.sv
module usr_bus_shreg
  import usr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_lo,
  input  logic         mode_hi,
  input  logic         ser_up_in,
  input  logic         ser_dn_in,
  input  logic         dis_a,
  input  logic         dis_b,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic [W-1:0] bus_oe,
  output logic         end_lo,
  output logic         end_hi
);
  localparam int TOP = W - 1;

  mode_e        mode;
  logic [W-1:0] q;
  logic [W-1:0] q_nxt;

  assign mode = mode_e'({mode_hi, mode_lo});

  usr_next_state #(.W(W)) u_nxt (
    .mode     (mode),
    .cur      (q),
    .load_val (bus_in),
    .ser_up   (ser_up_in),
    .ser_dn   (ser_dn_in),
    .nxt      (q_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  usr_drive_ctl #(.W(W)) u_drv (
    .mode  (mode),
    .dis_a (dis_a),
    .dis_b (dis_b),
    .oe    (bus_oe)
  );

  assign bus_out = q;
  assign end_lo  = q[0];
  assign end_hi  = q[TOP];
endmodule

// File: rtl/usr_bus_shreg_chk.sv
module usr_bus_shreg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mode_lo,
  input logic         mode_hi,
  input logic         ser_up_in,
  input logic         ser_dn_in,
  input logic         dis_a,
  input logic         dis_b,
  input logic [W-1:0] bus_in,
  input logic [W-1:0] bus_out,
  input logic [W-1:0] bus_oe,
  input logic         end_lo,
  input logic         end_hi
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hi && !mode_lo) |=> $stable(bus_out)); // R1
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_hi && mode_lo) |=> bus_out == {$past(bus_out[W-2:0]), $past(ser_up_in)}); // R2
  AST_SHIFT_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && !mode_lo) |=> bus_out == {$past(ser_dn_in), $past(bus_out[W-1:1])}); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && mode_lo) |=> bus_out == $past(bus_in)); // R4
  AST_RESET_ZERO: assert property (@(posedge clk)
    !rst_n |-> (bus_out == '0)); // R5
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_a || dis_b) |-> (bus_oe == '0)); // R6
  AST_LOAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_hi && mode_lo) |-> (bus_oe == '0)); // R7
  AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!dis_a && !dis_b && !(mode_hi && mode_lo)) |-> (bus_oe == '1)); // R8
  AST_END_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (end_lo == bus_out[0]) && (end_hi == bus_out[W-1])); // R9
endmodule

bind usr_bus_shreg usr_bus_shreg_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_lo   (mode_lo),
  .mode_hi   (mode_hi),
  .ser_up_in (ser_up_in),
  .ser_dn_in (ser_dn_in),
  .dis_a     (dis_a),
  .dis_b     (dis_b),
  .bus_in    (bus_in),
  .bus_out   (bus_out),
  .bus_oe    (bus_oe),
  .end_lo    (end_lo),
  .end_hi    (end_hi)
);

// File: tb/sim_usr_bus_shreg.sv
`timescale 1ns/1ps
module sim_usr_bus_shreg;
  localparam int W  = 8;
  localparam int W2 = 2 * W;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_lo, mode_hi, ser_up, ser_dn, dis_a, dis_b;
  logic [W2-1:0] bin;
  logic [W-1:0]  out0, out1, oe0, oe1;
  logic el0, eh0, el1, eh1;
  int checks = 0;
  int errors = 0;
  logic [W2-1:0] exp_q;

  always #2 clk = ~clk;

  usr_bus_shreg #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_lo(mode_lo), .mode_hi(mode_hi),
    .ser_up_in(ser_up), .ser_dn_in(el1), .dis_a(dis_a), .dis_b(dis_b),
    .bus_in(bin[W-1:0]), .bus_out(out0), .bus_oe(oe0),
    .end_lo(el0), .end_hi(eh0));

  usr_bus_shreg #(.W(W)) u1 (
    .clk(clk), .rst_n(rst_n), .mode_lo(mode_lo), .mode_hi(mode_hi),
    .ser_up_in(eh0), .ser_dn_in(ser_dn), .dis_a(dis_a), .dis_b(dis_b),
    .bus_in(bin[W2-1:W]), .bus_out(out1), .bus_oe(oe1),
    .end_lo(el1), .end_hi(eh1));

  task automatic chk(input bit ok, input string req, input logic [W2-1:0] act,
                     input logic [W2-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic su, input logic sd,
                      input logic [W2-1:0] b);
    @(negedge clk);
    {mode_hi, mode_lo} = m; ser_up = su; ser_dn = sd; bin = b;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk({out1, out0} == '0, "R5 reset state", {out1, out0}, '0);
  endtask

  task automatic t_load();
    step(2'b11, 0, 0, 16'hA5C3); exp_q = 16'hA5C3;
    chk({out1, out0} == exp_q, "R4 load", {out1, out0}, exp_q);
    chk({oe1, oe0} == '0, "R7 load releases drivers", {oe1, oe0}, '0);
    chk(el0 == exp_q[0] && eh1 == exp_q[W2-1] && eh0 == exp_q[W-1] && el1 == exp_q[W],
        "R9 end bits", {12'h0, eh1, el1, eh0, el0},
        {12'h0, exp_q[W2-1], exp_q[W], exp_q[W-1], exp_q[0]});
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) begin
      step(2'b00, 1, 1, 16'hFFFF);
      chk({out1, out0} == exp_q, "R1 hold", {out1, out0}, exp_q);
    end
    chk({oe1, oe0} == '1, "R8 drivers on in hold", {oe1, oe0}, '1);
  endtask

  task automatic t_shift_up(input logic [W2-1:0] pat);
    for (int i = 0; i < W2; i++) begin
      step(2'b01, pat[i], 0, 16'h0000);
      exp_q = {exp_q[W2-2:0], pat[i]};
      chk({out1, out0} == exp_q, "R2 R10 shift up chained", {out1, out0}, exp_q);
    end
  endtask

  task automatic t_shift_dn(input logic [W2-1:0] pat);
    for (int i = 0; i < W2; i++) begin
      step(2'b10, 0, pat[i], 16'h0000);
      exp_q = {pat[i], exp_q[W2-1:1]};
      chk({out1, out0} == exp_q, "R3 R10 shift down chained", {out1, out0}, exp_q);
    end
  endtask

  task automatic t_oe_matrix();
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 4; d++) begin
        logic [W2-1:0] e;
        @(negedge clk);
        {mode_hi, mode_lo} = m[1:0]; dis_a = d[0]; dis_b = d[1];
        #1;
        e = (d == 0 && m != 3) ? '1 : '0;
        chk({oe1, oe0} == e, "R6 R7 R8 drive enable", {oe1, oe0}, e);
      end
    @(negedge clk);
    {mode_hi, mode_lo} = 2'b00; dis_a = 0; dis_b = 0;
  endtask

  task automatic t_disabled_ops();
    @(negedge clk); dis_a = 1;
    step(2'b11, 0, 0, 16'h3C96); exp_q = 16'h3C96;
    chk({out1, out0} == exp_q, "R6 load while disabled", {out1, out0}, exp_q);
    chk(el0 == exp_q[0] && eh1 == exp_q[W2-1], "R9 ends active when disabled",
        {14'h0, eh1, el0}, {14'h0, exp_q[W2-1], exp_q[0]});
    @(negedge clk); dis_a = 0; dis_b = 1;
    step(2'b01, 1, 0, 16'h0000); exp_q = {exp_q[W2-2:0], 1'b1};
    chk({out1, out0} == exp_q, "R6 shift while disabled", {out1, out0}, exp_q);
    chk({oe1, oe0} == '0, "R6 drivers off", {oe1, oe0}, '0);
    @(negedge clk); dis_b = 0;
  endtask

  task automatic t_async_reset();
    step(2'b11, 0, 0, 16'hFFFF);
    @(posedge clk); #1;
    rst_n = 0;
    #0.5;
    chk({out1, out0} == '0, "R5 async clear before edge", {out1, out0}, '0);
    step(2'b11, 1, 1, 16'h5A5A);
    chk({out1, out0} == '0, "R5 reset overrides load", {out1, out0}, '0);
    step(2'b01, 1, 1, 16'h5A5A);
    chk({out1, out0} == '0, "R5 reset overrides shift", {out1, out0}, '0);
    @(negedge clk); rst_n = 1; exp_q = '0;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; mode_lo = 0; mode_hi = 0; ser_up = 0; ser_dn = 0;
    dis_a = 0; dis_b = 0; bin = '0; exp_q = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_load();
    t_hold();
    t_shift_up(16'hB2E1);
    t_shift_dn(16'h6D4F);
    t_oe_matrix();
    t_disabled_ops();
    t_async_reset();
    t_load();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule